// File: doc/BRIEF.md
# Fault Latch and Status Pin Logic

This block gathers the fault flags of a multi-channel high-side switch and turns them into one active-low status pin and one sticky fault word for serial readout. Each channel delivers six raw flags (over-temperature, over-current, severe short, output tied to supply while off, open load while off, open load while on). Two further flags, over-voltage and under-voltage, are shared by all channels. The detectors that raise these flags and the serial framing that reads the word lie outside the block.

Each fault class has its own release rule. The off-state faults and over-voltage follow their raw flag. Over-current, severe short, over-temperature and under-voltage are held per channel until that channel's turn-on command rises again. Open load while on is recorded in the fault word only. A read strobe from the serial logic empties the word, and any fault still present is recorded again on the next cycle. A clear pulse from the mode controller drops every held fault and empties the word.

Top module: `fault_status_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, `flt_n` is 1 and `fault_word` is all zero.
- R2: A raw supply-short-while-off or open-load-while-off flag on any channel drives `flt_n` to 0 one clock edge later, and `flt_n` returns to 1 one edge after the flag drops, provided nothing else holds it low.
- R3: Over-voltage drives `flt_n` low and sets `fault_word` bit NCH*6 only while `ov_rpt_en` is 1. With `ov_rpt_en` at 0 it changes neither the pin nor the word. It is not held once the raw flag drops.
- R4: Over-current (bit 1), severe short (bit 2) and over-temperature (bit 0) of channel c keep `flt_n` at 0 after the raw flag drops, until a rising edge of `ch_on[c]`. Channel c's fields occupy `fault_word` bits c*6 to c*6+5.
- R5: Under-voltage is held on every channel at once. The pin goes high only after every channel has seen a rising edge of `ch_on`. It is recorded in `fault_word` bit NCH*6+1.
- R6: A rising edge of `ch_on` on one channel releases only that channel's held faults.
- R7: A held fault whose raw flag is still present at the rising edge of `ch_on` stays held.
- R8: Open load while on (bit 5 of the channel field) sets its `fault_word` bit and never affects `flt_n`.
- R9: A `fault_word` bit is set one edge after its raw flag and stays set after the flag drops.
- R10: `rd_clr` empties `fault_word` at the next edge. A fault still present is set again at the edge after that.
- R11: `mode_clr` releases every held fault and empties `fault_word` at the next edge. It does not mask faults that follow their raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ot_raw | input | NCH | Over-temperature per channel |
| oc_raw | input | NCH | Over-current per channel |
| ssc_raw | input | NCH | Severe short per channel |
| sts_raw | input | NCH | Output tied to supply while off, per channel |
| olof_raw | input | NCH | Open load while off, per channel |
| olon_raw | input | NCH | Open load while on, per channel |
| ov_raw | input | 1 | Over-voltage, shared |
| uv_raw | input | 1 | Under-voltage, shared |
| ov_rpt_en | input | 1 | Over-voltage reporting enable (1 by default in the control logic) |
| ch_on | input | NCH | Per-channel turn-on command |
| rd_clr | input | 1 | First valid serial read strobe |
| mode_clr | input | 1 | Mode-transition clear pulse |
| flt_n | output | 1 | Active-low fault status pin |
| fault_word | output | NCH*6+2 | Sticky fault word |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. Pin and word are both registered, and the turn-on edge is found against the previous cycle's command in the same cycle it occurs. The bench changes inputs on the falling edge and reads `flt_n` and `fault_word` on the following falling edge, so every check looks at the state after exactly one rising edge. The re-set after a read or clear is due one edge later still, and it is checked in the vector that follows the strobe.

// File: rtl/fsu_pkg.sv
// Shared constants for the fault status unit: bit positions of the
// per-channel fault classes inside a channel field of the fault word.
package fsu_pkg;
    localparam int FLT_OT     = 0;
    localparam int FLT_OC     = 1;
    localparam int FLT_SSC    = 2;
    localparam int FLT_STS    = 3;
    localparam int FLT_OLOFF  = 4;
    localparam int FLT_OLON   = 5;
    localparam int FLT_PER_CH = 6;
endpackage

// File: rtl/fsu_on_edge.sv
// Turn-on edge detector: flags a rising edge of each channel's turn-on
// command. Assumes the command is already synchronous to clk.
module fsu_on_edge #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd,
    output logic [NCH-1:0] rise
);
    logic [NCH-1:0] cmd_q;

    // remember last cycle's command to find off-to-on changes
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd;
    end

    // a rise is on now and off in the previous cycle
    always_comb rise = cmd & ~cmd_q;
endmodule

// File: rtl/fsu_chan_latch.sv
// Per-channel holder for faults that need a fresh turn-on to release:
// over-temperature, over-current, severe short and under-voltage.
// Assumes clr and reissue are single-cycle, synchronous pulses.
module fsu_chan_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic reissue,
    input  logic ot,
    input  logic oc,
    input  logic ssc,
    input  logic uv,
    output logic held_nxt_any
);
    logic [3:0] held_q;
    logic [3:0] held_d;
    logic [3:0] raw;

    // gather the raw flags that this channel holds
    always_comb raw = {uv, ssc, oc, ot};

    // release on clear or turn-on, re-capture any flag still present
    always_comb begin
        if (clr)          held_d = '0;
        else if (reissue) held_d = raw;
        else              held_d = held_q | raw;
    end

    // hold state
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    // next-state summary lets the pin register track with one edge of delay
    always_comb held_nxt_any = |held_d;
endmodule

// File: rtl/fsu_fault_reg.sv
// Sticky fault word for serial readout. Bits accumulate until a read
// strobe or mode clear empties the word; live faults re-enter next cycle.
module fsu_fault_reg #(
    parameter int RW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rd,
    input  logic [RW-1:0] set_vec,
    output logic [RW-1:0] word
);
    // accumulate set bits, empty on read or clear
    always_ff @(posedge clk) begin
        if (!rst_n)         word <= '0;
        else if (clr || rd) word <= '0;
        else                word <= word | set_vec;
    end
endmodule

// File: rtl/fsu_pin.sv
// Registered active-low status pin driver. Assumes pull_low is a
// glitch-free combinational request computed in the clk domain.
module fsu_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pull_low,
    output logic pin_n
);
    // register the pin so it never glitches
    always_ff @(posedge clk) begin
        if (!rst_n) pin_n <= 1'b1;
        else        pin_n <= ~pull_low;
    end
endmodule

// File: rtl/fault_status_unit.sv
// Fault status unit: merges per-channel and shared fault flags into an
// active-low status pin and a sticky fault word. Assumes all raw flags
// are synchronous to clk and already filtered by their detectors.
module fault_status_unit
    import fsu_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int RW  = NCH*FLT_PER_CH + 2,
    localparam int OVB = NCH*FLT_PER_CH,
    localparam int UVB = NCH*FLT_PER_CH + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ot_raw,
    input  logic [NCH-1:0] oc_raw,
    input  logic [NCH-1:0] ssc_raw,
    input  logic [NCH-1:0] sts_raw,
    input  logic [NCH-1:0] olof_raw,
    input  logic [NCH-1:0] olon_raw,
    input  logic           ov_raw,
    input  logic           uv_raw,
    input  logic           ov_rpt_en,
    input  logic [NCH-1:0] ch_on,
    input  logic           rd_clr,
    input  logic           mode_clr,
    output logic           flt_n,
    output logic [RW-1:0]  fault_word
);
    logic [NCH-1:0] reissue;
    logic [NCH-1:0] held_any;
    logic [RW-1:0]  set_vec;
    logic           ov_live;
    logic           pull_low;

    fsu_on_edge #(.NCH(NCH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (ch_on),
        .rise  (reissue)
    );

    // over-voltage counts only while reporting is enabled
    always_comb ov_live = ov_raw & ov_rpt_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fsu_chan_latch u_latch (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr          (mode_clr),
            .reissue      (reissue[c]),
            .ot           (ot_raw[c]),
            .oc           (oc_raw[c]),
            .ssc          (ssc_raw[c]),
            .uv           (uv_raw),
            .held_nxt_any (held_any[c])
        );

        // place this channel's raw flags in its field of the word
        always_comb begin
            set_vec[c*FLT_PER_CH + FLT_OT]    = ot_raw[c];
            set_vec[c*FLT_PER_CH + FLT_OC]    = oc_raw[c];
            set_vec[c*FLT_PER_CH + FLT_SSC]   = ssc_raw[c];
            set_vec[c*FLT_PER_CH + FLT_STS]   = sts_raw[c];
            set_vec[c*FLT_PER_CH + FLT_OLOFF] = olof_raw[c];
            set_vec[c*FLT_PER_CH + FLT_OLON]  = olon_raw[c];
        end
    end

    // shared flags sit above the channel fields
    always_comb begin
        set_vec[OVB] = ov_live;
        set_vec[UVB] = uv_raw;
    end

    // pin request: held faults plus the ones that follow their raw flag
    always_comb pull_low = (|held_any) | (|sts_raw) | (|olof_raw) | ov_live;

    fsu_fault_reg #(.RW(RW)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_clr),
        .rd      (rd_clr),
        .set_vec (set_vec),
        .word    (fault_word)
    );

    fsu_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pull_low (pull_low),
        .pin_n    (flt_n)
    );
endmodule

// File: rtl/fault_status_chk.sv
// Assertion checker for fault_status_unit, attached by bind.
module fault_status_chk
    import fsu_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int RW  = NCH*FLT_PER_CH + 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] oc_raw,
    input logic [NCH-1:0] sts_raw,
    input logic [NCH-1:0] olof_raw,
    input logic           ov_raw,
    input logic           uv_raw,
    input logic           ov_rpt_en,
    input logic           rd_clr,
    input logic           mode_clr,
    input logic           flt_n,
    input logic [RW-1:0]  fault_word
);
    AST_FOLLOW_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sts_raw) || (|olof_raw) || (ov_raw && ov_rpt_en)) |=> !flt_n); // R2

    AST_OV_GATED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ov_rpt_en && !ov_raw) |=> ($past(fault_word[NCH*FLT_PER_CH]) || !fault_word[NCH*FLT_PER_CH] || $past(ov_raw))); // R3

    AST_OC_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((|oc_raw) && !mode_clr) |=> !flt_n); // R4

    AST_UV_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_raw && !mode_clr) |=> !flt_n); // R5

    AST_WORD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !mode_clr) |=> ((fault_word & $past(fault_word)) == $past(fault_word))); // R9

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (fault_word == '0)); // R10

    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clr && !(|sts_raw) && !(|olof_raw) && !(ov_raw && ov_rpt_en)) |=> (flt_n && fault_word == '0)); // R11
endmodule

bind fault_status_unit fault_status_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_raw     (oc_raw),
    .sts_raw    (sts_raw),
    .olof_raw   (olof_raw),
    .ov_raw     (ov_raw),
    .uv_raw     (uv_raw),
    .ov_rpt_en  (ov_rpt_en),
    .rd_clr     (rd_clr),
    .mode_clr   (mode_clr),
    .flt_n      (flt_n),
    .fault_word (fault_word)
);

// File: tb/sim_fault_status_unit.sv
`timescale 1ns/1ps
module sim_fault_status_unit;
    localparam int NCH = 4;
    localparam int RW  = 26;

    typedef struct packed {
        logic [3:0]    ot;
        logic [3:0]    oc;
        logic [3:0]    ssc;
        logic [3:0]    sts;
        logic [3:0]    olof;
        logic [3:0]    olon;
        logic          ov;
        logic          uv;
        logic          oven;
        logic [3:0]    on;
        logic          rd;
        logic          clr;
        logic          efs;
        logic [RW-1:0] ew;
    } vec_t;

    localparam int NV = 30;
    // ot, oc, ssc, sts, olof, olon, ov, uv, oven, on, rd, clr, exp pin, exp word
    localparam vec_t VT [NV] = '{
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b1,26'h0},       // 0 idle
        '{4'h0,4'h0,4'h0,4'h2,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b0,26'h200},     // 1 R2
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b1,26'h200},     // 2 R2 R9
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b1,1'b0,1'b1,26'h0},       // 3 R10
        '{4'h0,4'h4,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b0,26'h2000},    // 4 R4
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b0,26'h2000},    // 5 R4 held
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h1,1'b0,1'b0,1'b0,26'h2000},    // 6 R6
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h5,1'b0,1'b0,1'b1,26'h2000},    // 7 R4 release
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h8,1'b0,1'b0,1'b1,4'h5,1'b0,1'b0,1'b1,26'h802000},  // 8 R8
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,1'b0,4'h5,1'b0,1'b0,1'b1,26'h802000},  // 9 R3 off
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,1'b1,4'h5,1'b0,1'b0,1'b0,26'h1802000}, // 10 R3 on
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h5,1'b0,1'b0,1'b1,26'h1802000}, // 11 R3 drop
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h5,1'b1,1'b0,1'b1,26'h0},       // 12 R10
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,1'b1,4'h5,1'b0,1'b0,1'b0,26'h2000000}, // 13 R5
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h5,1'b0,1'b0,1'b0,26'h2000000}, // 14 R5 held
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h4,1'b0,1'b0,1'b0,26'h2000000}, // 15 R5
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h5,1'b0,1'b0,1'b0,26'h2000000}, // 16 R6
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b0,26'h2000000}, // 17 R5
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b1,26'h2000000}, // 18 R5 release
        '{4'h8,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'h7,1'b0,1'b0,1'b0,26'h2040000}, // 19 R4 ot
        '{4'h8,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b0,26'h2040000}, // 20 R7
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b0,26'h2040000}, // 21 R7 held
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b1,1'b1,26'h0},       // 22 R11
        '{4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,1'b0,26'h0},       // 23 R10
        '{4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b0,26'h4},       // 24 R10 re-set
        '{4'h0,4'h0,4'h0,4'h0,4'h2,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b0,26'h404},     // 25 R2 olof
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b1,1'b1,26'h0},       // 26 R11
        '{4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,26'h0},       // 27 R11 live
        '{4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b0,26'h8},       // 28 R11 re-set
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,1'b1,26'h8}        // 29 R2
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] ot_raw, oc_raw, ssc_raw, sts_raw, olof_raw, olon_raw, ch_on;
    logic           ov_raw, uv_raw, ov_rpt_en, rd_clr, mode_clr;
    logic           flt_n;
    logic [RW-1:0]  fault_word;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fault_status_unit #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ot_raw(ot_raw), .oc_raw(oc_raw), .ssc_raw(ssc_raw),
        .sts_raw(sts_raw), .olof_raw(olof_raw), .olon_raw(olon_raw),
        .ov_raw(ov_raw), .uv_raw(uv_raw), .ov_rpt_en(ov_rpt_en),
        .ch_on(ch_on), .rd_clr(rd_clr), .mode_clr(mode_clr),
        .flt_n(flt_n), .fault_word(fault_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        ot_raw = v.ot;  oc_raw = v.oc;  ssc_raw = v.ssc;
        sts_raw = v.sts; olof_raw = v.olof; olon_raw = v.olon;
        ov_raw = v.ov;  uv_raw = v.uv;  ov_rpt_en = v.oven;
        ch_on = v.on;   rd_clr = v.rd;  mode_clr = v.clr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 5000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        apply(VT[0]);
        repeat (3) @(negedge clk);
        chk("R1 pin in reset", 32'(flt_n), 32'h1);
        chk("R1 word in reset", 32'(fault_word), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin after reset", 32'(flt_n), 32'h1);
        chk("R1 word after reset", 32'(fault_word), 32'h0);

        // table walk: drive on falling edge, read one rising edge later
        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            @(negedge clk);
            chk($sformatf("vector %0d pin", i), 32'(flt_n), 32'(VT[i].efs));
            chk($sformatf("vector %0d word", i), 32'(fault_word), 32'(VT[i].ew));
        end

        // R8: open load while on alone, over many cycles, leaves the pin high
        apply(VT[29]);
        olon_raw = 4'hF;
        repeat (4) @(negedge clk);
        chk("R8 pin with olon only", 32'(flt_n), 32'h1);
        chk("R8 word olon bits", 32'(fault_word), 32'h0820828);

        // R1: reset in the middle of held faults restores idle state
        apply(VT[29]);
        ot_raw = 4'h1;
        sts_raw = 4'h2;
        @(negedge clk);
        chk("R4 ot held before reset", 32'(flt_n), 32'h0);
        apply(VT[0]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pin on mid reset", 32'(flt_n), 32'h1);
        chk("R1 word on mid reset", 32'(fault_word), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin after mid reset", 32'(flt_n), 32'h1);

        finish_run();
    end
endmodule